// File: doc/BRIEF.md
# Dual-Channel Timer Input Capture

This block sits next to a free-running 16-bit counter and records the counter value whenever one of two asynchronous input pins changes level. Each pin has two capture registers, one for rising transitions and one for falling transitions. Each register keeps the value from the latest transition of its kind. Each of the four transition kinds sets a sticky pending flag. A per-source enable mask lets any subset of those flags drive a single interrupt line.

Two capture formats are available. In narrow mode each channel stores an 8-bit window of the counter, and a 3-bit shift field in the configuration register chooses where that window starts. In wide mode channel 0 stores the full 16-bit counter value. Its low byte goes into the channel 0 registers and its high byte goes into the channel 1 registers, and channel 1 transitions no longer load anything. Software reaches every register through a small synchronous register bus with combinational read data.

Top module: `ecap_dual_top`

## Requirements
- R1: After reset every capture register, the configuration register (0x20), the pending register (0x21) and the enable register (0x2B) read 0, and `irq_o` is 0.
- R2: In narrow mode (config bit 7 = 0), a rising transition on `pin_i[k]` stores counter bits [n+7:n], where n is config bits 2:0, into the rising register of channel k (ch0 at 0x22, ch1 at 0x23). The counter value used is the one present at the third rising clock edge after the pin changes.
- R3: In narrow mode, a falling transition on `pin_i[k]` stores counter bits [n+7:n] into the falling register of channel k (ch0 at 0x24, ch1 at 0x25), with the same three-edge timing as R2.
- R4: A capture register changes only on a transition of its own kind and then holds the latest value. Bus writes to 0x22 to 0x25 have no effect.
- R5: In wide mode (config bit 7 = 1), a rising transition on `pin_i[0]` stores counter bits [7:0] at 0x22 and bits [15:8] of the same sample at 0x23, both in the same cycle.
- R6: In wide mode, a falling transition on `pin_i[0]` stores counter bits [7:0] at 0x24 and bits [15:8] of the same sample at 0x25.
- R7: In wide mode, transitions on `pin_i[1]` leave all four capture registers unchanged.
- R8: The enable register at 0x2B maps bit 0 to ch0 rising, bit 1 to ch0 falling, bit 2 to ch1 rising and bit 3 to ch1 falling. Bits 7:4 always read 0.
- R9: Each detected transition sets its flag in the pending register 0x21, using the same bit order as R8, whether or not that source is enabled. Writing 1 to a flag clears it. Writing 0 to a flag leaves it unchanged.
- R10: `irq_o` is high exactly when some pending flag and its enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_i | input | 16 | Free-running counter value |
| pin_i | input | 2 | Asynchronous capture inputs, one per channel |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, committed on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr`; unmapped addresses read 0 |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that `pin_i` is low while reset is held, so the synchronizer does not report a spurious transition on release. They also assume that the counter and mode settings seen at a clock edge are the ones the capture must use. The stimulus therefore releases reset with both pins low and changes pins, the counter and bus signals only on falling clock edges. Each pin change is held for several cycles, so every transition is seen exactly once. The counter is set to the expected value only for the one cycle in which the capture should sample it, and it carries distinct values on the cycles before and after that one. A capture taken a cycle early or a cycle late therefore reads back wrong.

// File: rtl/ecap_pkg.sv
package ecap_pkg;
   // register offsets; ordering of the capture block is decoded by software
   localparam logic [7:0] A_CFG  = 8'h20;
   localparam logic [7:0] A_STAT = 8'h21;
   localparam logic [7:0] A_C0R  = 8'h22;
   localparam logic [7:0] A_C1R  = 8'h23;
   localparam logic [7:0] A_C0F  = 8'h24;
   localparam logic [7:0] A_C1F  = 8'h25;
   localparam logic [7:0] A_IEN  = 8'h2B;
   // source bit index inside pending/enable vectors: 2*channel + kind
   localparam int SRC_RISE = 0;
   localparam int SRC_FALL = 1;
endpackage

// File: rtl/ecap_sync_edge.sv
module ecap_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ecap_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         last_q <= 1'b0;
      end else begin
         sh_q   <= {sh_q[STAGES-2:0], pin_i};
         last_q <= sh_q[STAGES-1];
      end
   end

   assign rise_o = sh_q[STAGES-1] & ~last_q;
   assign fall_o = ~sh_q[STAGES-1] & last_q;

   AST_EDGE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_o || fall_o) |=> !(rise_o || fall_o)); // R2
endmodule

// File: rtl/ecap_capture_bank.sv
module ecap_capture_bank #(
   parameter int TMR_W   = 16,
   parameter int DATA_W  = 8,
   parameter int PRESC_W = 3,
   parameter int NCH     = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [TMR_W-1:0]               timer_i,
   input  logic                           wide_i,
   input  logic [PRESC_W-1:0]             presc_i,
   input  logic [NCH-1:0]                 rise_i,
   input  logic [NCH-1:0]                 fall_i,
   output logic [NCH-1:0][DATA_W-1:0]     cap_rise_o,
   output logic [NCH-1:0][DATA_W-1:0]     cap_fall_o
);
   localparam int MAX_SHIFT = (1 << PRESC_W) - 1;

   if (TMR_W != 2 * DATA_W) begin : g_bad_width
      $error("ecap_capture_bank: TMR_W must be twice DATA_W");
   end
   if (DATA_W + MAX_SHIFT > TMR_W) begin : g_bad_presc
      $error("ecap_capture_bank: prescale window exceeds timer width");
   end
   if (NCH < 2) begin : g_bad_nch
      $error("ecap_capture_bank: wide mode needs two channels");
   end

   logic [DATA_W-1:0] slice_w;
   logic [DATA_W-1:0] lo_w;
   logic [DATA_W-1:0] hi_w;

   assign slice_w = DATA_W'(timer_i >> presc_i);
   assign lo_w    = timer_i[DATA_W-1:0];
   assign hi_w    = timer_i[TMR_W-1:DATA_W];

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic              ld_r, ld_f;
      logic [DATA_W-1:0] val_r, val_f;
      logic [DATA_W-1:0] q_r, q_f;

      if (c == 0) begin : g_low
         assign ld_r  = rise_i[0];
         assign ld_f  = fall_i[0];
         assign val_r = wide_i ? lo_w : slice_w;
         assign val_f = wide_i ? lo_w : slice_w;
      end else if (c == 1) begin : g_high
         assign ld_r  = wide_i ? rise_i[0] : rise_i[1];
         assign ld_f  = wide_i ? fall_i[0] : fall_i[1];
         assign val_r = wide_i ? hi_w : slice_w;
         assign val_f = wide_i ? hi_w : slice_w;
      end else begin : g_plain
         assign ld_r  = rise_i[c];
         assign ld_f  = fall_i[c];
         assign val_r = slice_w;
         assign val_f = slice_w;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q_r <= '0;
            q_f <= '0;
         end else begin
            if (ld_r) q_r <= val_r;
            if (ld_f) q_f <= val_f;
         end
      end

      assign cap_rise_o[c] = q_r;
      assign cap_fall_o[c] = q_f;
   end

   AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_i == '0 && fall_i == '0) |=> ($stable(cap_rise_o) && $stable(cap_fall_o))); // R4
   AST_WIDE_RISE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (wide_i && rise_i[0]) |=> ({cap_rise_o[1], cap_rise_o[0]} == $past(timer_i))); // R5
   AST_WIDE_FALL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (wide_i && fall_i[0]) |=> ({cap_fall_o[1], cap_fall_o[0]} == $past(timer_i))); // R6
   AST_WIDE_CH1_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (wide_i && !rise_i[0] && !fall_i[0]) |=> ($stable(cap_rise_o) && $stable(cap_fall_o))); // R7
endmodule

// File: rtl/ecap_irq_ctrl.sv
module ecap_irq_ctrl #(
   parameter int NSRC = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set_i,
   input  logic            clr_we_i,
   input  logic [NSRC-1:0] clr_mask_i,
   input  logic [NSRC-1:0] en_i,
   output logic [NSRC-1:0] pend_o,
   output logic            irq_o
);
   logic [NSRC-1:0] clr_w;

   assign clr_w = clr_we_i ? clr_mask_i : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_o <= '0;
      else        pend_o <= (pend_o & ~clr_w) | set_i;
   end

   assign irq_o = |(pend_o & en_i);

   AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i))); // R9
   AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_we_i |=> ((pend_o & $past(pend_o)) == $past(pend_o))); // R9
endmodule

// File: rtl/ecap_dual_top.sv
module ecap_dual_top #(
   parameter int TMR_W       = 16,
   parameter int DATA_W      = 8,
   parameter int PRESC_W     = 3,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TMR_W-1:0]  timer_i,
   input  logic [1:0]        pin_i,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o
);
   import ecap_pkg::*;

   localparam int NCH  = 2;
   localparam int NSRC = 2 * NCH;

   if (ADDR_W < 8) begin : g_bad_addr
      $error("ecap_dual_top: ADDR_W must be at least 8");
   end
   if (DATA_W < PRESC_W + 2 || DATA_W < NSRC) begin : g_bad_data
      $error("ecap_dual_top: DATA_W too small for config or flags");
   end

   logic [NCH-1:0]              rise_w, fall_w;
   logic [NSRC-1:0]             set_w, pend_w;
   logic [NCH-1:0][DATA_W-1:0]  cap_r_w, cap_f_w;
   logic                        cfg_wide_q;
   logic [PRESC_W-1:0]          cfg_presc_q;
   logic [NSRC-1:0]             ien_q;
   logic                        wr_cfg, wr_ien, wr_stat;
   logic                        unused_wdata;

   for (genvar c = 0; c < NCH; c++) begin : g_sync
      ecap_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .pin_i  (pin_i[c]),
         .rise_o (rise_w[c]),
         .fall_o (fall_w[c])
      );
      assign set_w[2*c + SRC_RISE] = rise_w[c];
      assign set_w[2*c + SRC_FALL] = fall_w[c];
   end

   assign wr_cfg  = bus_wr && (bus_addr == ADDR_W'(A_CFG));
   assign wr_ien  = bus_wr && (bus_addr == ADDR_W'(A_IEN));
   assign wr_stat = bus_wr && (bus_addr == ADDR_W'(A_STAT));
   assign unused_wdata = ^bus_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_wide_q  <= 1'b0;
         cfg_presc_q <= '0;
         ien_q       <= '0;
      end else begin
         if (wr_cfg) begin
            cfg_wide_q  <= bus_wdata[DATA_W-1];
            cfg_presc_q <= bus_wdata[PRESC_W-1:0];
         end
         if (wr_ien) ien_q <= bus_wdata[NSRC-1:0];
      end
   end

   ecap_capture_bank #(
      .TMR_W   (TMR_W),
      .DATA_W  (DATA_W),
      .PRESC_W (PRESC_W),
      .NCH     (NCH)
   ) bank_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .timer_i    (timer_i),
      .wide_i     (cfg_wide_q),
      .presc_i    (cfg_presc_q),
      .rise_i     (rise_w),
      .fall_i     (fall_w),
      .cap_rise_o (cap_r_w),
      .cap_fall_o (cap_f_w)
   );

   ecap_irq_ctrl #(.NSRC(NSRC)) irq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (set_w),
      .clr_we_i   (wr_stat),
      .clr_mask_i (bus_wdata[NSRC-1:0]),
      .en_i       (ien_q),
      .pend_o     (pend_w),
      .irq_o      (irq_o)
   );

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(A_CFG):  bus_rdata = {cfg_wide_q, {(DATA_W-1-PRESC_W){1'b0}}, cfg_presc_q};
         ADDR_W'(A_STAT): bus_rdata = DATA_W'(pend_w);
         ADDR_W'(A_C0R):  bus_rdata = cap_r_w[0];
         ADDR_W'(A_C1R):  bus_rdata = cap_r_w[1];
         ADDR_W'(A_C0F):  bus_rdata = cap_f_w[0];
         ADDR_W'(A_C1F):  bus_rdata = cap_f_w[1];
         ADDR_W'(A_IEN):  bus_rdata = DATA_W'(ien_q);
         default:         bus_rdata = '0;
      endcase
   end

   AST_IRQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ((pend_w & ien_q) != '0)); // R10
   AST_IEN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ien |=> $stable(ien_q)); // R8
endmodule

// File: tb/ecap_dual_top_tb.sv
`timescale 1ns/1ps
module ecap_dual_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] timer = 16'h0;
   logic [1:0]  pins = 2'b00;
   logic [7:0]  addr = 8'h0;
   logic        wr = 1'b0;
   logic [7:0]  wdata = 8'h0;
   logic [7:0]  rdata;
   logic        irq;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   ecap_dual_top dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .timer_i   (timer),
      .pin_i     (pins),
      .bus_addr  (addr),
      .bus_wr    (wr),
      .bus_wdata (wdata),
      .bus_rdata (rdata),
      .irq_o     (irq)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic rd_check(input string req, input logic [7:0] a, input logic [7:0] exp);
      logic [7:0] d;
      rd(a, d);
      check(req, d, exp);
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   // pin changes on a falling edge; the third rising edge after it samples t
   task automatic drive_edge(input int ch, input logic lvl, input logic [15:0] t);
      @(negedge clk);
      pins[ch] = lvl;
      timer = t ^ 16'h0F0F;
      @(negedge clk);
      @(negedge clk);
      timer = t;
      @(negedge clk);
      timer = ~t;
      @(negedge clk);
   endtask

   function automatic logic [7:0] window(input logic [15:0] t, input int n);
      logic [15:0] s;
      s = t >> n;
      return s[7:0];
   endfunction

   task automatic t_reset();
      rd_check("R1 cfg",    8'h20, 8'h00);
      rd_check("R1 status", 8'h21, 8'h00);
      rd_check("R1 c0r",    8'h22, 8'h00);
      rd_check("R1 c1r",    8'h23, 8'h00);
      rd_check("R1 c0f",    8'h24, 8'h00);
      rd_check("R1 c1f",    8'h25, 8'h00);
      rd_check("R1 ien",    8'h2B, 8'h00);
      check("R1 irq", {7'b0, irq}, 8'h00);
   endtask

   task automatic t_narrow_rise();
      wr_reg(8'h20, 8'h00);
      drive_edge(0, 1'b1, 16'hA5C3);
      rd_check("R2 ch0 rise n=0", 8'h22, window(16'hA5C3, 0));
      wr_reg(8'h20, 8'h03);
      drive_edge(1, 1'b1, 16'h1234);
      rd_check("R2 ch1 rise n=3", 8'h23, window(16'h1234, 3));
      rd_check("R2 ch0 rise kept", 8'h22, window(16'hA5C3, 0));
   endtask

   task automatic t_narrow_fall();
      wr_reg(8'h20, 8'h07);
      drive_edge(0, 1'b0, 16'hBEEF);
      rd_check("R3 ch0 fall n=7", 8'h24, window(16'hBEEF, 7));
      wr_reg(8'h20, 8'h05);
      drive_edge(1, 1'b0, 16'h6D2A);
      rd_check("R3 ch1 fall n=5", 8'h25, window(16'h6D2A, 5));
   endtask

   task automatic t_hold_ro();
      wr_reg(8'h22, 8'hFF);
      wr_reg(8'h23, 8'hFF);
      wr_reg(8'h24, 8'hFF);
      wr_reg(8'h25, 8'hFF);
      rd_check("R4 ro c0r", 8'h22, window(16'hA5C3, 0));
      rd_check("R4 ro c1r", 8'h23, window(16'h1234, 3));
      rd_check("R4 ro c0f", 8'h24, window(16'hBEEF, 7));
      rd_check("R4 ro c1f", 8'h25, window(16'h6D2A, 5));
      wr_reg(8'h20, 8'h00);
      drive_edge(0, 1'b1, 16'h0081);
      rd_check("R4 latest c0r", 8'h22, 8'h81);
      rd_check("R4 c0f untouched by rise", 8'h24, window(16'hBEEF, 7));
      drive_edge(0, 1'b0, 16'h0042);
      rd_check("R4 latest c0f", 8'h24, 8'h42);
   endtask

   task automatic t_wide();
      wr_reg(8'h20, 8'h80);
      rd_check("R5 cfg readback", 8'h20, 8'h80);
      drive_edge(0, 1'b1, 16'hCAFE);
      rd_check("R5 wide low", 8'h22, 8'hFE);
      rd_check("R5 wide high", 8'h23, 8'hCA);
      drive_edge(0, 1'b0, 16'h7B19);
      rd_check("R6 wide low", 8'h24, 8'h19);
      rd_check("R6 wide high", 8'h25, 8'h7B);
      drive_edge(1, 1'b1, 16'h5555);
      drive_edge(1, 1'b0, 16'h3333);
      rd_check("R7 c0r kept", 8'h22, 8'hFE);
      rd_check("R7 c1r kept", 8'h23, 8'hCA);
      rd_check("R7 c0f kept", 8'h24, 8'h19);
      rd_check("R7 c1f kept", 8'h25, 8'h7B);
   endtask

   task automatic t_irq();
      wr_reg(8'h20, 8'h00);
      wr_reg(8'h21, 8'h0F);
      rd_check("R9 cleared", 8'h21, 8'h00);
      wr_reg(8'h2B, 8'hF5);
      rd_check("R8 reserved read 0", 8'h2B, 8'h05);
      wr_reg(8'h2B, 8'h04);
      drive_edge(0, 1'b1, 16'h0101);
      rd_check("R9 ch0 rise flag while disabled", 8'h21, 8'h01);
      check("R10 irq masked", {7'b0, irq}, 8'h00);
      drive_edge(1, 1'b1, 16'h0202);
      rd_check("R9 ch1 rise flag", 8'h21, 8'h05);
      check("R10 irq on enabled source", {7'b0, irq}, 8'h01);
      wr_reg(8'h21, 8'h00);
      rd_check("R9 write zero keeps", 8'h21, 8'h05);
      wr_reg(8'h21, 8'h04);
      rd_check("R9 w1c", 8'h21, 8'h01);
      check("R10 irq drops", {7'b0, irq}, 8'h00);
      wr_reg(8'h2B, 8'h02);
      drive_edge(0, 1'b0, 16'h0303);
      rd_check("R8 bit1 is ch0 fall", 8'h21, 8'h03);
      check("R8 ch0 fall enabled irq", {7'b0, irq}, 8'h01);
   endtask

   initial begin : wdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_narrow_rise();
      t_narrow_fall();
      t_hold_ro();
      t_wide();
      t_irq();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule